// File: doc/BRIEF.md
# Dual-Clock FIFO with Half-Occupancy Flags

This block carries data words from a producer clock domain to a consumer clock domain whose clocks are unrelated. The producer writes while `wr_full` is low. The consumer sees the word at the head of the queue on `rd_data` whenever `rd_empty` is low, and pops it by raising `rd_en`. Each side also has its own half-occupancy flag. That flag is high when the side's own view of the fill level is at least half of the depth.

Each side keeps a binary pointer that is one bit wider than the address, plus a Gray copy of it. Only the Gray copy crosses to the other clock, through two receiving-clock flip-flops. There the full Gray word is turned back into binary: each binary bit is the XOR of all Gray bits at or above it. The binary difference of the two pointers gives the fill count. Full and empty come from Gray comparisons. Full means the two top bits are inverted and the rest are equal. Empty means the two words are equal. Every side folds its flags into a registered level state, so each flag is a decode of one register. Because of the synchronizer delay the flags are pessimistic. Full and the write-side half flag can stay high for a few cycles after a read. Empty can stay high for a few cycles after a write.

The level state of each side takes one of four values:
- EMPTY: no flags set.
- LOW: data present, below half.
- HIGH: at or above half.
- FULL: write side only.

The next level is chosen each cycle with this priority:
1. The Gray match (full or empty).
2. Count at or above half.
3. Nonzero count.
4. Zero.

Top module: `dcfifo_halfmark`

## Requirements
- R1: After reset, `rd_empty` is 1, while `wr_full`, `wr_half` and `rd_half` are 0.
- R2: Words leave on `rd_data` in the order they were accepted. A write is accepted when `wr_en` is high and `wr_full` is low at a `wr_clk` rising edge.
- R3: Once DEPTH words are held and no reads are pending, `wr_full` reads 1.
- R4: A write attempted while `wr_full` is 1 is dropped: the write pointer holds, and the word never appears on the read side.
- R5: A read attempted while `rd_empty` is 1 has no effect. The read pointer holds, so the next word written is the next word read.
- R6: After a single write into an empty FIFO, `rd_empty` falls within five `rd_clk` cycles.
- R7: In a settled state, `wr_half` is 0 with DEPTH/2-1 words held and 1 with DEPTH/2 words held.
- R8: In a settled state, `rd_half` is 0 with DEPTH/2-1 words held and 1 with DEPTH/2 words held.
- R9: Flags never overstate resources:
  - `rd_empty` low implies at least one word is stored.
  - `rd_half` high implies at least DEPTH/2 words are stored.
  - `wr_full` low implies fewer than DEPTH words are stored.
  - `wr_half` low implies fewer than DEPTH/2 words are stored.
- R10: Each Gray pointer changes by at most one bit per clock of its own domain, and pointers wrap around correctly over many passes.
- R11: `wr_full` high implies `wr_half` high, and `rd_half` high implies `rd_empty` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-domain reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to write |
| wr_full | output | 1 | No room from the producer's view |
| wr_half | output | 1 | Producer view of fill level is at least DEPTH/2 |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-domain reset, active low |
| rd_en | input | 1 | Pop request |
| rd_data | output | WIDTH | Word at the head of the queue |
| rd_empty | output | 1 | Nothing to read from the consumer's view |
| rd_half | output | 1 | Consumer view of fill level is at least DEPTH/2 |

## Verification
The bound checker watches, on every edge of the relevant clock:
- that dropped writes and dropped reads leave the Gray pointers untouched;
- that each Gray pointer moves by at most one bit per clock;
- that the flag pairs on each side stay consistent.

Other behaviour depends on the two clocks together, so only the bench scenarios can show it. This covers data ordering, the exact half-depth boundary once both views have settled, the delay before empty clears, and the rule that no flag ever claims space or data that does not exist while unrelated clocks run random traffic.

// File: rtl/hm_pkg.sv
package hm_pkg;
    // Fill level as seen by one side of the FIFO.
    typedef enum logic [1:0] {
        LVL_EMPTY = 2'd0,
        LVL_LOW   = 2'd1,
        LVL_HIGH  = 2'd2,
        LVL_FULL  = 2'd3
    } hm_level_e;
endpackage

// File: rtl/hm_sync.sv
module hm_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hm_store.sv
module hm_store #(
    parameter int AW    = 4,
    parameter int WIDTH = 8
) (
    input  logic             wr_clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [WIDTH-1:0] cells [ENTRIES];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/hm_side.sv
module hm_side
    import hm_pkg::*;
#(
    parameter int AW    = 4,
    parameter bit IS_WR = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  logic [AW:0] far_gray,
    output logic [AW:0] ptr_bin,
    output logic [AW:0] ptr_gray,
    output hm_level_e   level,
    output logic        take
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] HALF_CNT = PW'(1) << (AW - 1);

    logic [PW-1:0] far_bin;
    logic [PW-1:0] bin_n;
    logic [PW-1:0] gray_n;
    logic [PW-1:0] occ;
    logic          match;
    hm_level_e     level_n;

    // Whole-word Gray to binary: prefix XOR from the top bit down.
    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign far_bin[i] = ^far_gray[PW-1:i];
    end

    if (IS_WR) begin : g_wr
        assign take  = req && (level != LVL_FULL);
        assign occ   = bin_n - far_bin;
        assign match = (gray_n == {~far_gray[PW-1:PW-2], far_gray[PW-3:0]});
    end else begin : g_rd
        assign take  = req && (level != LVL_EMPTY);
        assign occ   = far_bin - bin_n;
        assign match = (gray_n == far_gray);
    end

    assign bin_n  = ptr_bin + PW'(take);
    assign gray_n = (bin_n >> 1) ^ bin_n;

    always_comb begin
        if (match) begin
            level_n = IS_WR ? LVL_FULL : LVL_EMPTY;
        end else if (occ >= HALF_CNT) begin
            level_n = LVL_HIGH;
        end else if (occ != '0) begin
            level_n = LVL_LOW;
        end else begin
            level_n = LVL_EMPTY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_bin  <= '0;
            ptr_gray <= '0;
            level    <= LVL_EMPTY;
        end else begin
            ptr_bin  <= bin_n;
            ptr_gray <= gray_n;
            level    <= level_n;
        end
    end
endmodule

// File: rtl/dcfifo_halfmark.sv
module dcfifo_halfmark
    import hm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_full,
    output logic             wr_half,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_empty,
    output logic             rd_half
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] w_bin, w_gray, r_bin, r_gray;
    logic [PW-1:0] w_gray_at_rd, r_gray_at_wr;
    logic          w_take, r_take;
    hm_level_e     w_level, r_level;

    hm_side #(.AW(AW), .IS_WR(1'b1)) u_wside (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .req      (wr_en),
        .far_gray (r_gray_at_wr),
        .ptr_bin  (w_bin),
        .ptr_gray (w_gray),
        .level    (w_level),
        .take     (w_take)
    );

    hm_side #(.AW(AW), .IS_WR(1'b0)) u_rside (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .req      (rd_en),
        .far_gray (w_gray_at_rd),
        .ptr_bin  (r_bin),
        .ptr_gray (r_gray),
        .level    (r_level),
        .take     (r_take)
    );

    hm_sync #(.W(PW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (w_gray),
        .q     (w_gray_at_rd)
    );

    hm_sync #(.W(PW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (r_gray),
        .q     (r_gray_at_wr)
    );

    hm_store #(.AW(AW), .WIDTH(WIDTH)) u_store (
        .wr_clk (wr_clk),
        .we     (w_take),
        .waddr  (w_bin[AW-1:0]),
        .wdata  (wr_data),
        .raddr  (r_bin[AW-1:0]),
        .rdata  (rd_data)
    );

    always_comb begin
        unique case (w_level)
            LVL_EMPTY: begin wr_full = 1'b0; wr_half = 1'b0; end
            LVL_LOW:   begin wr_full = 1'b0; wr_half = 1'b0; end
            LVL_HIGH:  begin wr_full = 1'b0; wr_half = 1'b1; end
            LVL_FULL:  begin wr_full = 1'b1; wr_half = 1'b1; end
        endcase
    end

    always_comb begin
        unique case (r_level)
            LVL_EMPTY: begin rd_empty = 1'b1; rd_half = 1'b0; end
            LVL_LOW:   begin rd_empty = 1'b0; rd_half = 1'b0; end
            LVL_HIGH:  begin rd_empty = 1'b0; rd_half = 1'b1; end
            LVL_FULL:  begin rd_empty = 1'b0; rd_half = 1'b1; end
        endcase
    end
endmodule

// File: rtl/hm_checker.sv
module hm_checker #(
    parameter int PW = 5
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          wr_full,
    input logic          wr_half,
    input logic          rd_empty,
    input logic          rd_half,
    input logic [PW-1:0] w_gray,
    input logic [PW-1:0] r_gray
);
    // R4: a write offered while full leaves the write pointer where it was
    assert_wr_hold_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_full && wr_en) |=> (w_gray == $past(w_gray)));

    // R5: a read offered while empty leaves the read pointer where it was
    assert_rd_hold_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_empty && rd_en) |=> (r_gray == $past(r_gray)));

    // R10: Gray pointers move by at most one bit per clock
    assert_wgray_step_R10: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    assert_rgray_step_R10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1);

    // R11: flag pairs on each side stay consistent
    assert_full_half_R11: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_full |-> wr_half);

    assert_half_empty_R11: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_half |-> !rd_empty);
endmodule

bind dcfifo_halfmark hm_checker #(.PW(PW)) u_hm_checker (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_full  (wr_full),
    .wr_half  (wr_half),
    .rd_empty (rd_empty),
    .rd_half  (rd_half),
    .w_gray   (w_gray),
    .r_gray   (r_gray)
);

// File: tb/test_dcfifo_halfmark.sv
`timescale 1ns/1ps
module test_dcfifo_halfmark;
    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_rst_n = 1'b0;
    logic       rd_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       wr_full, wr_half, rd_empty, rd_half;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int accepted = 0;
    logic [7:0] model_q[$];

    always #5   wr_clk = ~wr_clk;   // 100 MHz producer clock
    always #6.5 rd_clk = ~rd_clk;   // unrelated consumer clock

    dcfifo_halfmark #(.DEPTH(DEPTH), .WIDTH(8)) i_dcfifo_halfmark (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_full  (wr_full),
        .wr_half  (wr_half),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_empty (rd_empty),
        .rd_half  (rd_half)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One producer cycle: pessimism checks, then drive the request.
    task automatic wr_step(input bit en, input logic [7:0] d);
        @(negedge wr_clk);
        if (!wr_full) check(model_q.size() < DEPTH, "R9 not-full", model_q.size(), DEPTH - 1);
        if (!wr_half) check(model_q.size() < HALF, "R9 not-half", model_q.size(), HALF - 1);
        if (wr_full)  check(wr_half == 1'b1, "R11 full-half", int'(wr_half), 1);
        wr_en   = en;
        wr_data = d;
        if (en && !wr_full) begin
            model_q.push_back(d);
            accepted++;
        end
    endtask

    // One consumer cycle: pessimism checks, data check, then drive the request.
    task automatic rd_step(input bit en);
        @(negedge rd_clk);
        if (!rd_empty) check(model_q.size() > 0, "R9 not-empty", model_q.size(), 1);
        if (rd_half) begin
            check(model_q.size() >= HALF, "R9 half", model_q.size(), HALF);
            check(rd_empty == 1'b0, "R11 half-empty", int'(rd_empty), 0);
        end
        rd_en = en;
        if (en && !rd_empty) begin
            if (model_q.size() == 0) begin
                check(1'b0, "R2 unexpected word", int'(rd_data), -1);
            end else begin
                check(rd_data == model_q[0], "R2 order", int'(rd_data), int'(model_q[0]));
                void'(model_q.pop_front());
            end
        end
    endtask

    task automatic settle();
        repeat (8) wr_step(1'b0, 8'h00);
        repeat (8) rd_step(1'b0);
    endtask

    task automatic drain();
        for (int k = 0; k < 400 && (model_q.size() > 0 || !rd_empty); k++) rd_step(1'b1);
        rd_step(1'b0);
    endtask

    initial begin
        int n;
        int wp;
        int rp;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge wr_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);

        // R1: reset state
        check(rd_empty == 1'b1, "R1 rd_empty", int'(rd_empty), 1);
        check(wr_full == 1'b0, "R1 wr_full", int'(wr_full), 0);
        check(wr_half == 1'b0, "R1 wr_half", int'(wr_half), 0);
        check(rd_half == 1'b0, "R1 rd_half", int'(rd_half), 0);

        // R5: reads while empty are dropped
        repeat (3) rd_step(1'b1);
        rd_step(1'b0);
        check(rd_empty == 1'b1, "R5 still empty", int'(rd_empty), 1);

        // R6: single write, empty must clear quickly
        wr_step(1'b1, 8'h5A);
        wr_step(1'b0, 8'h00);
        n = 0;
        while (rd_empty && n < 10) begin
            @(negedge rd_clk);
            n++;
        end
        check(n <= 5, "R6 empty latency", n, 5);
        // R5: the word written after dropped reads is the next word read
        check(rd_data == 8'h5A, "R5 head word", int'(rd_data), 'h5A);
        rd_step(1'b1);
        rd_step(1'b0);
        settle();
        check(rd_empty == 1'b1, "R5 empty after pop", int'(rd_empty), 1);

        // R7/R8: half boundary, one below then exactly half
        for (int i = 0; i < HALF - 1; i++) wr_step(1'b1, 8'(8'h10 + i));
        settle();
        check(wr_half == 1'b0, "R7 below half", int'(wr_half), 0);
        check(rd_half == 1'b0, "R8 below half", int'(rd_half), 0);
        wr_step(1'b1, 8'h20);
        settle();
        check(wr_half == 1'b1, "R7 at half", int'(wr_half), 1);
        check(rd_half == 1'b1, "R8 at half", int'(rd_half), 1);

        // R3: fill to depth
        for (int i = 0; i < DEPTH - HALF; i++) wr_step(1'b1, 8'(8'h30 + i));
        settle();
        check(wr_full == 1'b1, "R3 full at depth", int'(wr_full), 1);

        // R4: writes while full dropped, value 0xEE must never be read
        repeat (3) wr_step(1'b1, 8'hEE);
        settle();
        check(model_q.size() == DEPTH, "R4 model size", model_q.size(), DEPTH);
        check(wr_full == 1'b1, "R4 still full", int'(wr_full), 1);
        drain();
        settle();
        check(rd_empty == 1'b1, "R4 nothing extra stored", int'(rd_empty), 1);
        check(model_q.size() == 0, "R4 model drained", model_q.size(), 0);

        // Random traffic on both clocks
        accepted = 0;
        fork
            begin
                for (int i = 0; i < 2000; i++) begin
                    case (i / 500)
                        0: wp = 80;
                        1: wp = 30;
                        2: wp = 60;
                        default: wp = 95;
                    endcase
                    wr_step(($urandom % 100) < wp, 8'($urandom));
                end
                wr_step(1'b0, 8'h00);
            end
            begin
                for (int i = 0; i < 1600; i++) begin
                    case (i / 400)
                        0: rp = 30;
                        1: rp = 85;
                        2: rp = 60;
                        default: rp = 95;
                    endcase
                    rd_step(($urandom % 100) < rp);
                end
                rd_step(1'b0);
            end
        join
        settle();
        drain();
        settle();
        check(rd_empty == 1'b1, "R2 final empty", int'(rd_empty), 1);
        check(model_q.size() == 0, "R2 all words read", model_q.size(), 0);
        // R10: pointers have wrapped many times with order intact
        check(accepted > 4 * DEPTH, "R10 pointer wraps", accepted, 4 * DEPTH + 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500us;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule